// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into bytes and stores them in a receive queue. Each queue entry holds the data byte together with that byte's own error flags. The frame format can be set: 5 to 8 data bits, an optional parity bit in one of four modes, and one or two stop bits. Bit timing comes from an oversampling strobe supplied from outside (`OVS` strobes per bit). Each bit is sampled once, in the middle of its bit period.

Software reads an entry in two steps. It first reads the error port, which shows the head entry's flags. It then pops the entry through the data port. An overrun is not tied to the byte that was lost. It is shown on the next error read instead. A summary flag tells software that unread errors are still waiting. Three interrupt sources are provided: queue level, receive error, and line-idle timeout. The timeout fires even when the queue is empty. Each interrupt status bit is cleared by writing one to it.

Top module: `uart_rx_efifo`

## Requirements
- R1: `dataLen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives LSB first. A byte is stored right-aligned, with its unused upper bits at zero.
- R2: `parSel` 4 selects odd parity, 5 even parity, 6 a parity bit forced to 1, and 7 a parity bit forced to 0. Any code below 4 means the frame has no parity bit. A parity bit that does not match the selected mode sets flag bit 1 of the entry.
- R3: `stopSel` 0 selects one stop bit and 1 selects two. If any stop bit is sampled low, flag bit 2 (framing) of the entry is set.
- R4: A frame whose every bit is sampled low, from the start bit through the last stop bit, sets flag bit 3 (break) as well as framing. A break frame is stored as data 0. The receiver does not look for a new start bit until the line has gone high again.
- R5: The queue holds `DEPTH` (16) entries. `fifoCnt` gives the count modulo 16 and `fifoFull` is set at 16, so a full queue reads count 0 with full set. Reset leaves the queue empty and all status at 0.
- R6: A frame that arrives while the queue is full is dropped. The next error read then shows flag bit 0 (overrun) set, and later reads do not.
- R7: `errData` shows the flags of the head entry, and `rxData` shows its data. A `dataRd` pulse pops the entry. Entries leave in arrival order, and each keeps its own flags.
- R8: `fifoErr` is set while an overrun is pending or while any stored entry with a nonzero flag has not yet had its error status read. An `errRd` pulse, or popping the entry, retires that entry's error.
- R9: Interrupt status bit 0 is set while the count is at or above the level chosen by `trigSel`: codes 0, 1, 2 and 3 select 4, 8, 12 and 16 entries.
- R10: While `toutEn` is high and the receiver is idle, 3 character times of idle line (3 × frame bits × `OVS` strobes) set interrupt status bit 2. This happens even when the queue is empty. The timeout fires only once per idle period and is re-armed by the next start bit.
- R11: A `fifoRst` pulse empties the queue, drops any pending overrun, and retires every pending entry error.
- R12: Interrupt status bit 1 is set when an entry with any error is stored or when an overrun occurs. A one in `irqClr` clears the matching status bit. `irq` is the OR of the status bits whose bit in `intEn` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversampling strobe, `OVS` per bit |
| rxd | input | 1 | Serial line, idle high |
| dataLen | input | 2 | Data-length code |
| stopSel | input | 1 | Stop-bit count select |
| parSel | input | 3 | Parity mode code |
| trigSel | input | 2 | Level-interrupt threshold code |
| toutEn | input | 1 | Idle-timeout enable |
| intEn | input | 3 | Interrupt enables (0 level, 1 error, 2 timeout) |
| fifoRst | input | 1 | Queue reset pulse |
| errRd | input | 1 | Error-status read strobe |
| dataRd | input | 1 | Data read (pop) strobe |
| irqClr | input | 3 | Write-one-to-clear for interrupt status |
| rxData | output | 8 | Head entry data |
| errData | output | 4 | Head entry flags, with pending overrun in bit 0 |
| fifoCnt | output | 4 | Entry count modulo 16 |
| fifoFull | output | 1 | Queue full |
| fifoErr | output | 1 | Unread errors pending |
| irqStat | output | 3 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. `dataRd` and `errRd` are single-cycle strobes. The frame-format inputs do not change while a frame is being received. `fifoRst` is not raised in the same cycle as reads. The stimulus keeps to all three: it changes the format only while the line is idle and the receiver has finished, and it raises one control strobe at a time, on the falling clock edge. The serial line is held for exactly `OVS` strobes per bit, so the mid-bit sampling point always lies well inside each bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {BK_DATA = 2'd0, BK_PAR = 2'd1, BK_STOP = 2'd2} bitKind_e;

  typedef struct packed {
    logic     frameStart;
    logic     shift;
    bitKind_e kind;
    logic     lineBit;
    logic     frameEnd;
    logic     toutHit;
  } rxStrb_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int TOUT_CHARS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] dataLen,
  input  logic       stopSel,
  input  logic       parEn,
  input  logic       toutEn,
  output rxStrb_t    strb
);
  localparam int TW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int TOW  = $clog2(TOUT_CHARS * OVS * 12 + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} state_e;

  state_e         state;
  logic           rxMeta, rxS;
  logic [TW-1:0]  tickCnt;
  logic [3:0]     bitIdx;
  logic [TOW-1:0] toutCnt;
  logic           toutFired;

  logic [3:0]     nData, lastIdx, frameBits;
  logic [TOW-1:0] toutLimit;

  assign nData     = 4'd5 + {2'b00, dataLen};
  assign lastIdx   = nData + {3'b000, parEn} + {3'b000, stopSel};
  assign frameBits = lastIdx + 4'd2;
  assign toutLimit = TOW'(TOUT_CHARS * OVS) * TOW'(frameBits);

  always_comb begin
    strb            = '0;
    strb.frameStart = (state == S_IDLE) && tick && !rxS;
    strb.shift      = (state == S_BITS) && tick && (tickCnt == TW'(OVS - 1));
    strb.lineBit    = rxS;
    if (bitIdx < nData)                strb.kind = BK_DATA;
    else if (parEn && bitIdx == nData) strb.kind = BK_PAR;
    else                               strb.kind = BK_STOP;
    strb.frameEnd   = strb.shift && (bitIdx == lastIdx);
    strb.toutHit    = (state == S_IDLE) && tick && toutEn && !toutFired &&
                      (toutCnt == toutLimit - TOW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxS     <= 1'b1;
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
      case (state)
        S_IDLE: if (strb.frameStart) begin
          state   <= S_START;
          tickCnt <= '0;
        end
        S_START: if (tick) begin
          if (tickCnt == TW'(HALF - 1)) begin
            state   <= rxS ? S_IDLE : S_BITS;
            tickCnt <= '0;
            bitIdx  <= '0;
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        S_BITS: if (strb.shift) begin
          tickCnt <= '0;
          if (strb.frameEnd) state <= rxS ? S_IDLE : S_HOLD;
          else               bitIdx <= bitIdx + 4'd1;
        end else if (tick) begin
          tickCnt <= tickCnt + TW'(1);
        end
        default: if (rxS) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toutCnt   <= '0;
      toutFired <= 1'b0;
    end else begin
      if (strb.frameStart)   toutFired <= 1'b0;
      else if (strb.toutHit) toutFired <= 1'b1;
      if (state != S_IDLE || !toutEn)  toutCnt <= '0;
      else if (tick && !toutFired)     toutCnt <= toutCnt + TOW'(1);
    end
  end

  // R10: a timeout strobe is never repeated in the following cycle
  a_r10_single_tout: assert property (@(posedge clk) disable iff (!rstN)
    strb.toutHit |=> !strb.toutHit);
endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxStrb_t                  strb,
  input  logic [1:0]               dataLen,
  input  logic [2:0]               parSel,
  input  logic [1:0]               trigSel,
  input  logic                     fifoRst,
  input  logic                     errRd,
  input  logic                     dataRd,
  input  logic [2:0]               irqClr,
  input  logic [2:0]               intEn,
  output logic [7:0]               rxData,
  output logic [3:0]               errData,
  output logic [$clog2(DEPTH)-1:0] fifoCnt,
  output logic                     fifoFull,
  output logic                     fifoErr,
  output logic [2:0]               irqStat,
  output logic                     irq
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = AW + 1;
  localparam int QUARTER = DEPTH / 4;

  logic [7:0]       dataSh;
  logic             parBit, stopBad, anyOne;
  logic [7:0]       endData;
  logic             endFrame, endBreak, endPar, dataPar;
  logic [3:0]       pushFlags;

  logic [7:0]       memD [DEPTH];
  logic [3:0]       memF [DEPTH];
  logic [DEPTH-1:0] unread, unreadNext;
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    cnt, lvl;
  logic             ovrPend, full, doPush, doPop, ovf, errSet;

  // frame assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSh <= '0; parBit <= 1'b0; stopBad <= 1'b0; anyOne <= 1'b0;
    end else if (strb.frameStart) begin
      dataSh <= '0; parBit <= 1'b0; stopBad <= 1'b0; anyOne <= 1'b0;
    end else if (strb.shift) begin
      anyOne <= anyOne | strb.lineBit;
      case (strb.kind)
        BK_DATA: dataSh  <= {strb.lineBit, dataSh[7:1]};
        BK_PAR:  parBit  <= strb.lineBit;
        default: stopBad <= stopBad | !strb.lineBit;
      endcase
    end
  end

  assign endData  = dataSh >> (2'd3 - dataLen);
  assign dataPar  = ^endData;
  assign endFrame = stopBad | !strb.lineBit;
  assign endBreak = !anyOne && !strb.lineBit;

  always_comb begin
    case (parSel)
      3'd4:    endPar = !(dataPar ^ parBit);
      3'd5:    endPar = dataPar ^ parBit;
      3'd6:    endPar = !parBit;
      3'd7:    endPar = parBit;
      default: endPar = 1'b0;
    endcase
  end
  assign pushFlags = {endBreak, endFrame, endPar, 1'b0};

  // queue
  assign full   = (cnt == CW'(DEPTH));
  assign doPush = strb.frameEnd && !full;
  assign ovf    = strb.frameEnd && full;
  assign doPop  = dataRd && (cnt != '0);

  always_comb begin
    unreadNext = unread;
    if ((errRd || doPop) && cnt != '0) unreadNext[rdPtr] = 1'b0;
    if (doPush) unreadNext[wrPtr] = |pushFlags;
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      memD[wrPtr] <= endData;
      memF[wrPtr] <= pushFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; cnt <= '0; ovrPend <= 1'b0; unread <= '0;
    end else if (fifoRst) begin
      wrPtr <= '0; rdPtr <= '0; cnt <= '0; ovrPend <= 1'b0; unread <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      cnt    <= cnt + CW'(doPush) - CW'(doPop);
      unread <= unreadNext;
      if (ovf)        ovrPend <= 1'b1;
      else if (errRd) ovrPend <= 1'b0;
    end
  end

  assign rxData   = (cnt != '0) ? memD[rdPtr] : 8'h00;
  assign errData  = ((cnt != '0) ? memF[rdPtr] : 4'h0) | {3'b000, ovrPend};
  assign fifoCnt  = cnt[AW-1:0];
  assign fifoFull = cnt[AW];
  assign fifoErr  = ovrPend | (|unread);

  // interrupts
  assign lvl    = CW'((int'(trigSel) + 1) * QUARTER);
  assign errSet = (doPush && |pushFlags) || ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStat <= '0;
    else       irqStat <= (irqStat & ~irqClr) | {strb.toutHit, errSet, (cnt >= lvl)};
  end
  assign irq = |(irqStat & intEn);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEPTH));
  a_r5_empty_pop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && cnt == '0 && !strb.frameEnd && !fifoRst) |=> cnt == '0);
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameEnd && full && !dataRd && !fifoRst) |=> (ovrPend && cnt == CW'(DEPTH)));
  a_r11_reset_empties: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> (cnt == '0 && !ovrPend && unread == '0));
  a_r12_clear_tout: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr[2] && !strb.toutHit) |=> !irqStat[2]);
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleTick,
  input  logic                     rxd,
  input  logic [1:0]               dataLen,
  input  logic                     stopSel,
  input  logic [2:0]               parSel,
  input  logic [1:0]               trigSel,
  input  logic                     toutEn,
  input  logic [2:0]               intEn,
  input  logic                     fifoRst,
  input  logic                     errRd,
  input  logic                     dataRd,
  input  logic [2:0]               irqClr,
  output logic [7:0]               rxData,
  output logic [3:0]               errData,
  output logic [$clog2(DEPTH)-1:0] fifoCnt,
  output logic                     fifoFull,
  output logic                     fifoErr,
  output logic [2:0]               irqStat,
  output logic                     irq
);
  rxStrb_t strb;

  uart_rx_ctrl #(.OVS(OVS), .TOUT_CHARS(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .rxd(rxd),
    .dataLen(dataLen), .stopSel(stopSel), .parEn(parSel[2]),
    .toutEn(toutEn), .strb(strb)
  );

  uart_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataLen(dataLen), .parSel(parSel),
    .trigSel(trigSel), .fifoRst(fifoRst), .errRd(errRd), .dataRd(dataRd),
    .irqClr(irqClr), .intEn(intEn), .rxData(rxData), .errData(errData),
    .fifoCnt(fifoCnt), .fifoFull(fifoFull), .fifoErr(fifoErr),
    .irqStat(irqStat), .irq(irq)
  );
endmodule

// File: tb/uart_rx_efifo_test.sv
module uart_rx_efifo_test;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] dataLen = 2'd3;
  logic       stopSel = 1'b0;
  logic [2:0] parSel = 3'd0;
  logic [1:0] trigSel = 2'd3;
  logic       toutEn = 1'b0;
  logic [2:0] intEn = 3'b000;
  logic       fifoRst = 1'b0, errRd = 1'b0, dataRd = 1'b0;
  logic [2:0] irqClr = 3'b000;
  logic [7:0] rxData;
  logic [3:0] errData;
  logic [3:0] fifoCnt;
  logic       fifoFull, fifoErr, irq;
  logic [2:0] irqStat;

  int nChk = 0, nFail = 0;
  logic [7:0] qD[$];
  logic [3:0] qF[$];
  bit mOvr = 0;

  always #5 clk = ~clk;

  uart_rx_efifo uut (
    .clk(clk), .rstN(rstN), .sampleTick(1'b1), .rxd(rxd), .dataLen(dataLen),
    .stopSel(stopSel), .parSel(parSel), .trigSel(trigSel), .toutEn(toutEn),
    .intEn(intEn), .fifoRst(fifoRst), .errRd(errRd), .dataRd(dataRd),
    .irqClr(irqClr), .rxData(rxData), .errData(errData), .fifoCnt(fifoCnt),
    .fifoFull(fifoFull), .fifoErr(fifoErr), .irqStat(irqStat), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxd = b;
    waitc(OVS);
  endtask

  // one frame in the current format; the expected entry goes to the model
  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit badStop, input bit brk);
    int nd = 5 + int'(dataLen);
    logic [7:0] dm = d & 8'((1 << nd) - 1);
    logic good, pb;
    logic [3:0] f = 4'h0;
    if (brk) dm = 8'h00;
    case (parSel)
      3'd4: good = ~(^dm);
      3'd5: good = ^dm;
      3'd6: good = 1'b1;
      default: good = 1'b0;
    endcase
    pb = brk ? 1'b0 : (good ^ badPar);
    sendBit(1'b0);
    for (int i = 0; i < nd; i++) sendBit(dm[i]);
    if (parSel[2]) begin
      sendBit(pb);
      if (pb != good) f[1] = 1'b1;
    end
    for (int s = 0; s <= int'(stopSel); s++)
      sendBit(!(brk || (badStop && s == int'(stopSel))));
    if (brk || badStop) f[2] = 1'b1;
    if (brk) f[3] = 1'b1;
    rxd = 1'b1;
    waitc(4);
    if (qD.size() == 16) mOvr = 1;
    else begin qD.push_back(dm); qF.push_back(f); end
  endtask

  task automatic readErr(input string req);
    chk(req, errData, int'(qF[0] | {3'b000, mOvr}));
    errRd = 1'b1; @(negedge clk); errRd = 1'b0;
    mOvr = 0;
  endtask

  task automatic popData(input string req);
    chk(req, rxData, qD[0]);
    dataRd = 1'b1; @(negedge clk); dataRd = 1'b0;
    void'(qD.pop_front()); void'(qF.pop_front());
  endtask

  task automatic readEntry(input string req);
    readErr(req);
    popData(req);
  endtask

  task automatic chkLevel(input string req);
    chk(req, fifoCnt, qD.size() % 16);
    chk(req, fifoFull, qD.size() == 16);
  endtask

  task automatic clearAll();
    irqClr = 3'b111; @(negedge clk); irqClr = 3'b000;
  endtask

  initial begin
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    // R5: reset state
    chkLevel("R5 reset");
    chk("R5 reset err", fifoErr, 0);
    chk("R5 reset irq", {irqStat, irq}, 0);

    // R1: data lengths
    sendFrame(8'hA5, 0, 0, 0);
    sendFrame(8'h3C, 0, 0, 0);
    chkLevel("R1 count");
    readEntry("R1 8-bit");
    readEntry("R7 order");
    dataLen = 2'd0;
    sendFrame(8'h1F, 0, 0, 0);
    sendFrame(8'hF5, 0, 0, 0);
    dataLen = 2'd2;
    sendFrame(8'h7E, 0, 0, 0);
    dataLen = 2'd1;
    sendFrame(8'hEB, 0, 0, 0);
    readEntry("R1 5-bit");
    readEntry("R1 5-bit masked");
    readEntry("R1 7-bit");
    readEntry("R1 6-bit");

    // R2: parity modes
    dataLen = 2'd3;
    parSel = 3'd4; sendFrame(8'h01, 0, 0, 0); sendFrame(8'h01, 1, 0, 0);
    parSel = 3'd5; sendFrame(8'h03, 0, 0, 0); sendFrame(8'h03, 1, 0, 0);
    parSel = 3'd6; sendFrame(8'h10, 0, 0, 0); sendFrame(8'h10, 1, 0, 0);
    parSel = 3'd7; sendFrame(8'h20, 0, 0, 0); sendFrame(8'h20, 1, 0, 0);
    parSel = 3'd1; sendFrame(8'h55, 0, 0, 0);
    for (int i = 0; i < 9; i++) readEntry("R2 parity");

    // R3, R8, R12: framing, summary flag, error interrupt
    parSel = 3'd0;
    clearAll();
    intEn = 3'b010;
    stopSel = 1'b1; sendFrame(8'h81, 0, 0, 0); sendFrame(8'h81, 0, 1, 0);
    stopSel = 1'b0; sendFrame(8'h42, 0, 1, 0);
    readEntry("R3 two stops good");
    chk("R8 summary set", fifoErr, 1);
    chk("R12 error status", irqStat[1], 1);
    chk("R12 irq", irq, 1);
    readErr("R3 second stop low");
    chk("R8 still pending", fifoErr, 1);
    popData("R3 data");
    readErr("R3 one stop low");
    chk("R8 summary clear", fifoErr, 0);
    popData("R3 data");
    clearAll();
    chk("R12 w1c", irqStat[1], 0);
    chk("R12 irq low", irq, 0);

    // R4: break
    sendFrame(8'h00, 0, 0, 1);
    parSel = 3'd5; sendFrame(8'h00, 0, 0, 1);
    parSel = 3'd0; sendFrame(8'h66, 0, 0, 0);
    readEntry("R4 break 8N1");
    readEntry("R4 break 8E1");
    readEntry("R4 after break");

    // R5, R6, R9: level, full, overrun
    clearAll();
    trigSel = 2'd0;
    for (int i = 0; i < 3; i++) sendFrame(8'(8'h10 + i), 0, 0, 0);
    chk("R9 below level", irqStat[0], 0);
    sendFrame(8'h13, 0, 0, 0);
    chk("R9 at level", irqStat[0], 1);
    for (int i = 4; i < 16; i++) sendFrame(8'(8'h10 + i), 0, 0, 0);
    chkLevel("R5 full");
    chk("R5 full count zero", fifoCnt, 0);
    sendFrame(8'hEE, 0, 0, 0);
    chkLevel("R6 dropped");
    chk("R6 summary", fifoErr, 1);
    readEntry("R6 overrun on head");
    readEntry("R6 overrun once");
    while (qD.size() > 0) readEntry("R7 drain");
    clearAll();
    chk("R9 cleared when below", irqStat[0], 0);
    trigSel = 2'd3;

    // R11: queue reset
    for (int i = 0; i < 17; i++) sendFrame(8'(i), 0, (i == 0), 0);
    chk("R11 pre", fifoErr, 1);
    fifoRst = 1'b1; @(negedge clk); fifoRst = 1'b0;
    qD.delete(); qF.delete(); mOvr = 0;
    chkLevel("R11 empty");
    chk("R11 errors retired", fifoErr, 0);
    sendFrame(8'h99, 0, 0, 0);
    readEntry("R11 no stale overrun");

    // R10: idle timeout on an empty queue
    clearAll();
    intEn = 3'b100;
    toutEn = 1'b1;
    waitc(470);
    chk("R10 not yet", irqStat[2], 0);
    waitc(20);
    chk("R10 fired empty", irqStat[2], 1);
    chk("R10 irq", irq, 1);
    clearAll();
    waitc(600);
    chk("R10 once per idle", irqStat[2], 0);
    sendFrame(8'h5A, 0, 0, 0);
    waitc(490);
    chk("R10 rearmed", irqStat[2], 1);
    readEntry("R10 data");
    toutEn = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    waitc(200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule